// File: doc/BRIEF.md
# FSK Tone Modulator (1200/2200 Hz)

This block turns a serial bit stream from a UART transmit line into a phase-continuous digital sine tone for a half-duplex 1200 bit/s field-bus link. A high bit (mark) is sent as 1200 Hz and a low bit (space) as 2200 Hz. Frames are not buffered. The level on the data input selects the tone frequency in every clock, so bit timing belongs entirely to the UART that feeds the block. Analog shaping, filtering and line drive come after this block.

The block runs from one of three master clock rates: 460.8 kHz, 921.6 kHz or 1.8432 MHz. A 2-bit select input names the rate in use, and each rate has its own pair of phase increments. An active-low request-to-send input gates the transmitter. While that input is high, the output amplitude is zero and the phase is held at zero, so every transmission starts from phase zero. All inputs are synchronous to the master clock. One signed sample leaves the block on every clock.

Top module: `fsk_tone_mod`

## Requirements
- R1: While reset is high, and after its release until the first clock edge, the sample is 0 and both the valid strobe and the active flag are 0.
- R2: With request-to-send low and data high, the output is a 1200 Hz tone. It is within 0.5% at each clock option and uses the phase increment round(1200·2^24/f_clk).
- R3: With request-to-send low and data low, the output is a 2200 Hz tone. It is within 0.5% at each clock option and uses the increment round(2200·2^24/f_clk).
- R4: The clock select uses 0 for 460.8 kHz, 1 for 921.6 kHz and 2 for 1.8432 MHz. Code 3 acts exactly like code 2.
- R5: A change of the data level changes only the phase step from the next clock on. The 24-bit phase carries on from its present value and never jumps.
- R6: While request-to-send is high, the data and select inputs are ignored. From the first clock that sees request-to-send high, the sample is 0 and the active flag is 0.
- R7: The phase is held at zero while request-to-send is high. The first sample after request-to-send falls is therefore 0. The sample k clocks after the fall is the table value at ((k-1)·increment mod 2^24) >> 18.
- R8: Out of reset, the sample-valid strobe is high on every clock.
- R9: The sample is an 8-bit two's-complement code equal to round(127·sin(2π·i/64)), where i is the top 6 bits of the 24-bit phase. It is registered one clock after that phase.
- R10: The active flag equals the inverted request-to-send level seen at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (one of the three supported rates) |
| rst_i | input | 1 | Synchronous active-high reset |
| clk_sel_i | input | 2 | Master clock rate code |
| txd_i | input | 1 | Serial data from the UART, 1 = mark, 0 = space |
| rts_n_i | input | 1 | Request-to-send, active low, gates the transmitter |
| smp_valid_o | output | 1 | Sample strobe, one per clock out of reset |
| smp_o | output | 8 | Signed tone amplitude |
| tx_active_o | output | 1 | Transmitter enabled flag |

## Verification
A data-level change can land on the same clock as a request-to-send edge. In that cycle the tone choice and the phase restart or gating act together. The bench provokes both cases. It flips the data input on the very cycle it lowers request-to-send to start a burst, and it toggles data while raising and holding request-to-send high. A behavioural model with its own increment and sine arithmetic is compared with the outputs on every clock, so any wrong priority between the restart, the gating and the increment choice shows up as a sample mismatch. Measured zero-crossing rates then confirm both tone frequencies at every clock option.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  localparam int unsigned SEL_W = 2;

  // Rounded phase increment: f_tone * 2^w / f_clk.
  function automatic logic [63:0] calc_inc(input logic [63:0] f_tone,
                                           input logic [63:0] f_clk,
                                           input int unsigned w);
    return ((f_tone << w) + (f_clk >> 1)) / f_clk;
  endfunction

  // Rounded amplitude code of amp*sin(2*pi*k/depth), built from a Taylor series.
  function automatic int sine_code(input int k, input int depth, input int amp);
    real x;
    real term;
    real acc;
    real pi;
    pi = 3.14159265358979323846;
    x = 2.0 * pi * real'(k) / real'(depth);
    if (x > pi) x = x - 2.0 * pi;
    term = x;
    acc = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc = acc + term;
    end
    acc = acc * real'(amp);
    if (acc >= 0.0) return $rtoi(acc + 0.5);
    else return -$rtoi(-acc + 0.5);
  endfunction

endpackage

// File: rtl/fsk_incr_lut.sv
module fsk_incr_lut
  import fsk_mod_pkg::*;
#(
  parameter int unsigned PHASE_W  = 24,
  parameter int unsigned CLK0_HZ  = 460800,
  parameter int unsigned CLK1_HZ  = 921600,
  parameter int unsigned CLK2_HZ  = 1843200,
  parameter int unsigned MARK_HZ  = 1200,
  parameter int unsigned SPACE_HZ = 2200
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               bit_i,
  output logic [PHASE_W-1:0] inc_o
);

  localparam int unsigned N_SEL = 1 << SEL_W;

  logic [PHASE_W-1:0] tab [2*N_SEL];

  // Each select code gets a space/mark pair; code 3 reuses the fastest clock.
  for (genvar i = 0; i < N_SEL; i++) begin : g_opt
    localparam int unsigned FCLK = (i == 0) ? CLK0_HZ :
                                   (i == 1) ? CLK1_HZ : CLK2_HZ;
    localparam logic [63:0] INC_SP = calc_inc(64'(SPACE_HZ), 64'(FCLK), PHASE_W);
    localparam logic [63:0] INC_MK = calc_inc(64'(MARK_HZ), 64'(FCLK), PHASE_W);
    assign tab[2*i]   = INC_SP[PHASE_W-1:0];
    assign tab[2*i+1] = INC_MK[PHASE_W-1:0];
  end

  assign inc_o = tab[{sel_i, bit_i}];

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int unsigned PHASE_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) phase_q <= '0;
    else                 phase_q <= phase_q + inc_i;
  end

  assign phase_o = phase_q;

  AST_IDLE_PHASE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> phase_o == '0); // R7

  AST_INC_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    run_i |-> inc_i != '0); // R4

endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
  import fsk_mod_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 en_i,
  input  logic [AW-1:0]        addr_i,
  output logic signed [DW-1:0] data_o
);

  localparam int DEPTH = 1 << AW;
  localparam int AMP   = (1 << (DW - 1)) - 1;

  logic signed [DW-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int CODE = sine_code(i, DEPTH, AMP);
    localparam logic [31:0] CODE_V = CODE;
    assign rom[i] = CODE_V[DW-1:0];
  end

  // Registered read; a gated transmitter forces the sample to zero.
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) data_o <= '0;
    else                data_o <= rom[addr_i];
  end

  AST_NO_MIN_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
    data_o != {1'b1, {(DW-1){1'b0}}}); // R9

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
  import fsk_mod_pkg::*;
#(
  parameter int unsigned PHASE_W  = 24,
  parameter int unsigned LUT_AW   = 6,
  parameter int unsigned AMP_W    = 8,
  parameter int unsigned CLK0_HZ  = 460800,
  parameter int unsigned CLK1_HZ  = 921600,
  parameter int unsigned CLK2_HZ  = 1843200,
  parameter int unsigned MARK_HZ  = 1200,
  parameter int unsigned SPACE_HZ = 2200
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [1:0]              clk_sel_i,
  input  logic                    txd_i,
  input  logic                    rts_n_i,
  output logic                    smp_valid_o,
  output logic signed [AMP_W-1:0] smp_o,
  output logic                    tx_active_o
);

  logic               run;
  logic [PHASE_W-1:0] inc;
  logic [PHASE_W-1:0] phase;
  logic               valid_q;
  logic               active_q;

  assign run = !rts_n_i;

  fsk_incr_lut #(
    .PHASE_W (PHASE_W),
    .CLK0_HZ (CLK0_HZ),
    .CLK1_HZ (CLK1_HZ),
    .CLK2_HZ (CLK2_HZ),
    .MARK_HZ (MARK_HZ),
    .SPACE_HZ(SPACE_HZ)
  ) incr_i (
    .sel_i(clk_sel_i),
    .bit_i(txd_i),
    .inc_o(inc)
  );

  fsk_phase_acc #(
    .PHASE_W(PHASE_W)
  ) acc_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (run),
    .inc_i  (inc),
    .phase_o(phase)
  );

  fsk_sine_rom #(
    .AW(LUT_AW),
    .DW(AMP_W)
  ) rom_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (run),
    .addr_i(phase[PHASE_W-1 -: LUT_AW]),
    .data_o(smp_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      valid_q  <= 1'b1;
      active_q <= run;
    end
  end

  assign smp_valid_o = valid_q;
  assign tx_active_o = active_q;

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    rts_n_i |=> (smp_o == '0) && !tx_active_o); // R6

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rts_n_i) |=> smp_o == '0); // R7

  AST_VALID_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> smp_valid_o); // R8

  AST_ACTIVE_TRACK: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> tx_active_o == !$past(rts_n_i)); // R10

endmodule

// File: tb/fsk_tone_mod_tb_top.sv
`timescale 1ns/1ps
module fsk_tone_mod_tb_top;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        sel;
  logic              txd;
  logic              rts_n;
  logic              vld;
  logic signed [7:0] smp;
  logic              act;

  int    n_chk = 0;
  int    n_err = 0;
  bit    cmp_en = 1'b0;
  string cur_tag = "R9";

  real clks [4] = '{460800.0, 921600.0, 1843200.0, 1843200.0};

  longint m_ph  = 0;
  int     m_smp = 0;
  bit     m_vld = 1'b0;
  bit     m_act = 1'b0;

  always #2.5 clk = ~clk;

  fsk_tone_mod dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .clk_sel_i  (sel),
    .txd_i      (txd),
    .rts_n_i    (rts_n),
    .smp_valid_o(vld),
    .smp_o      (smp),
    .tx_active_o(act)
  );

  function automatic longint exp_inc(input int s, input bit b);
    real f;
    f = b ? 1200.0 : 2200.0;
    return longint'($rtoi(f * 16777216.0 / clks[s] + 0.5));
  endfunction

  function automatic int exp_sine(input longint k);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 64.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else return -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actual, input longint expected);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // Behavioural reference, updated on the same edge as the design.
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_smp = 0; m_vld = 1'b0; m_act = 1'b0;
    end else begin
      m_smp = rts_n ? 0 : exp_sine(m_ph >> 18);
      m_act = !rts_n;
      m_vld = 1'b1;
      m_ph  = rts_n ? 0 : ((m_ph + exp_inc(int'(sel), txd)) & 64'hFFFFFF);
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(vld == m_vld, "R8", "valid strobe", longint'(vld), longint'(m_vld));
      chk(act == m_act, "R10", "active flag", longint'(act), longint'(m_act));
      chk(int'(smp) == m_smp, cur_tag, "sample", longint'(smp), longint'(m_smp));
    end
  end

  task automatic measure(input int s, input bit b, input string req);
    int     k;
    longint t, t0, tl;
    int     prev, cur;
    real    f, tgt, err;
    sel = 2'(s);
    txd = b;
    k = 0; t = 0; t0 = 0; tl = 0;
    prev = int'(smp);
    while (k < 11 && t < 20000) begin
      @(negedge clk);
      t++;
      cur = int'(smp);
      if (prev < 0 && cur >= 0) begin
        if (k == 0) t0 = t;
        tl = t;
        k++;
      end
      prev = cur;
    end
    tgt = b ? 1200.0 : 2200.0;
    f = (tl > t0) ? 10.0 * clks[s] / real'(tl - t0) : 0.0;
    err = (f - tgt) / tgt;
    if (err < 0.0) err = -err;
    chk(err <= 0.005, req, "tone frequency Hz", longint'($rtoi(f)), longint'($rtoi(tgt)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL all requirements: watchdog expired, actual 190000 cycles expected fewer");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; sel = 2'd0; txd = 1'b0; rts_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    chk(smp == 0, "R1", "sample in reset", longint'(smp), 0);
    chk(vld == 1'b0, "R1", "valid in reset", longint'(vld), 0);
    chk(act == 1'b0, "R1", "active in reset", longint'(act), 0);
    rst = 1'b0;
    cmp_en = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      // start a burst with data flipping in the same cycle as the gate opens
      cur_tag = "R7";
      txd = ~txd;
      rts_n = 1'b0;
      @(negedge clk);
      chk(smp == 0, "R7", "first sample after gate opens", longint'(smp), 0);
      cur_tag = (s == 3) ? "R4" : "R2";
      measure(s, 1'b1, cur_tag);
      cur_tag = (s == 3) ? "R4" : "R3";
      measure(s, 1'b0, cur_tag);
      // R6: gate closes while data keeps toggling
      cur_tag = "R6";
      rts_n = 1'b1;
      txd = ~txd;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        chk(smp == 0 && act == 1'b0, "R6", "gated sample/active",
            longint'(smp), 0);
        txd = ~txd;
        sel = 2'(c);
      end
    end

    // R5: frequent bit changes, checked cycle by cycle against the model
    cur_tag = "R5 R9";
    sel = 2'd1;
    rts_n = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if ((c % 37) == 0) txd = ~txd;
      if ((c % 211) == 0) txd = 1'b1;
    end

    // R7: restart from phase zero, then follow the mark increment
    cur_tag = "R7";
    rts_n = 1'b1;
    txd = 1'b0;
    repeat (3) @(negedge clk);
    sel = 2'd0;
    txd = 1'b1;
    rts_n = 1'b0;
    @(negedge clk);
    chk(smp == 0, "R7", "sample k=1", longint'(smp), 0);
    repeat (19) @(negedge clk);
    chk(int'(smp) == exp_sine(((19 * exp_inc(0, 1'b1)) & 64'hFFFFFF) >> 18),
        "R7", "sample k=20", longint'(smp),
        longint'(exp_sine(((19 * exp_inc(0, 1'b1)) & 64'hFFFFFF) >> 18)));

    rts_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b0;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule